// File: doc/BRIEF.md
# Hardware Cursor Overlay with Four-Entry Palette

This block lays a single 1024-pixel cursor over a pixel stream that already carries mixed video and graphics. The cursor bitmap is kept in a small internal RAM as 2-bit colour codes, loaded by a CPU through a dedicated write port. The same 1024-pixel store can be viewed as one of five rectangles, from tall and narrow to short and wide. Each code selects one of four palette entries. An entry holds a reduced-precision YUV colour and a 2-bit transparency level, which gives four blend weights between cursor and background.

The cursor can sit anywhere on the raster, and it can extend past a screen edge. Pixels that fall outside its rectangle pass through unchanged. Position and shape are written into shadow registers and copied to the active set on a field-start pulse, so a cursor never tears in the middle of a field. Palette writes take effect at once. The underlying pixel and the raster position go through two register stages, and the blended pixel leaves together with the matching position.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted all outputs are zero. After reset every palette entry has transparency 0, the active position is (0,0) and the active shape code is 2.
- R2: The pixel and the raster position sampled at clock edge k appear on the outputs after edge k+1, which is a latency of two cycles.
- R3: A pixel outside the active cursor rectangle, or one whose palette entry has transparency 0, leaves the block equal to the underlying pixel.
- R4: Shape code s, for s from 0 to 4, gives a width of 8<<s and a height of 128>>s. A CPU write of shape code 5, 6 or 7 is ignored and the shadow shape keeps its value.
- R5: The cursor pixel at column c and row r reads the RAM at address r*width+c. A RAM write puts the 2-bit code ram_wdata at address ram_addr.
- R6: Register addresses are 0 for X position, 1 for Y position, 2 for shape (bits [2:0]) and 4+i for palette entry i. Address 3 is ignored. A palette word packs Y in bits [15:10], U in [9:6], V in [5:2] and transparency in [1:0].
- R7: Before blending, the 6-bit Y becomes {y, y[5:4]} and each 4-bit chroma value c becomes {c, c}. With transparency 3 the output equals this expanded colour.
- R8: With transparency t inside the rectangle, each component is floor((cursor*t + under*(3-t))/3).
- R9: Position and shape writes reach only pixels sampled after an edge at which field_start is high. A write at that same edge waits for the following field_start.
- R10: A RAM write at the same edge as the cursor reads that cell returns the old code for that pixel. The new code is used from the next read on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| field_start | input | 1 | Pulse that copies the shadow position and shape into the active set |
| pix_x | input | 12 | Raster column of the incoming pixel |
| pix_y | input | 12 | Raster line of the incoming pixel |
| in_y | input | 8 | Underlying luma |
| in_u | input | 8 | Underlying U |
| in_v | input | 8 | Underlying V |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| ram_wr | input | 1 | Bitmap write strobe |
| ram_addr | input | 10 | Bitmap write address |
| ram_wdata | input | 2 | Bitmap code to write |
| out_y | output | 8 | Blended luma |
| out_u | output | 8 | Blended U |
| out_v | output | 8 | Blended V |
| out_pos_x | output | 12 | Column delayed to line up with the output pixel |
| out_pos_y | output | 12 | Line delayed to line up with the output pixel |

## Verification
Two pairs of operations can land on the same clock edge. A CPU bitmap write can hit the cell the raster is reading at that moment, and a shadow register write can coincide with field_start. The bench forces both on purpose. It steers the raster onto the cursor origin while it rewrites those same cells, and it writes a new position in the very cycle of a field pulse. A reference model in the bench applies the same ordering: the old code is read before the write lands, and the active set is copied from the pre-write shadow. Every output pixel is compared with that model, so a design that forwards new data early or latches the fresh shadow shows up as a mismatch.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
   typedef struct packed {
      logic [5:0] y;
      logic [3:0] u;
      logic [3:0] v;
      logic [1:0] t;
   } pal_entry_t;

   localparam int PAL_W = $bits(pal_entry_t);
endpackage

// File: rtl/cursor_store.sv
module cursor_store #(
   parameter int AW = 10,
   parameter int DW = 2
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // read returns the pre-write contents on an address collision
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/cursor_palette.sv
module cursor_palette
   import cursor_pkg::*;
#(
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  pal_entry_t    wr_data,
   input  logic [IW-1:0] rd_idx,
   output pal_entry_t    rd_entry
);
   localparam int N = 1 << IW;

   pal_entry_t ent [N];

   for (genvar g = 0; g < N; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           ent[g] <= '0;
         else if (wr_en && wr_idx == IW'(g))   ent[g] <= wr_data;
      end
   end

   assign rd_entry = ent[rd_idx];
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
   import cursor_pkg::*;
(
   input  logic [2:0][7:0] under,
   input  pal_entry_t      ent,
   input  logic            hit,
   output logic [2:0][7:0] mixed
);
   localparam int NCH = 3;

   logic [2:0][7:0] cur;
   logic [1:0]      alpha;

   assign cur[0] = {ent.y, ent.y[5:4]};
   assign cur[1] = {ent.u, ent.u};
   assign cur[2] = {ent.v, ent.v};
   assign alpha  = hit ? ent.t : 2'd0;

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic [9:0] acc;
      assign acc      = 10'(cur[g]) * 10'(alpha) + 10'(under[g]) * 10'(2'd3 - alpha);
      assign mixed[g] = 8'(acc / 10'd3);
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cursor_pkg::*;
#(
   parameter int XW         = 12,
   parameter int AW         = 10,
   parameter int CODE_W     = 2,
   parameter int BASE_LOG   = 3,
   parameter int NUM_SHAPES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic [XW-1:0]     pix_x,
   input  logic [XW-1:0]     pix_y,
   input  logic [7:0]        in_y,
   input  logic [7:0]        in_u,
   input  logic [7:0]        in_v,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   input  logic              ram_wr,
   input  logic [AW-1:0]     ram_addr,
   input  logic [CODE_W-1:0] ram_wdata,
   output logic [7:0]        out_y,
   output logic [7:0]        out_u,
   output logic [7:0]        out_v,
   output logic [XW-1:0]     out_pos_x,
   output logic [XW-1:0]     out_pos_y
);
   localparam int SHW       = $clog2(NUM_SHAPES);
   localparam int SHAPE_RST = 2;

   if (AW < BASE_LOG + NUM_SHAPES - 1) begin : g_bad_aw
      $error("cursor_overlay: AW too small for the shape set");
   end
   if (XW < AW) begin : g_bad_xw
      $error("cursor_overlay: XW must cover the cursor extent");
   end

   // shadow and active position/shape
   logic [XW-1:0]  sh_x, sh_y, act_x, act_y;
   logic [SHW-1:0] sh_shape, act_shape;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_x <= '0; sh_y <= '0; sh_shape <= SHW'(SHAPE_RST);
         act_x <= '0; act_y <= '0; act_shape <= SHW'(SHAPE_RST);
      end else begin
         if (field_start) begin
            act_x <= sh_x; act_y <= sh_y; act_shape <= sh_shape;
         end
         if (reg_wr && !reg_addr[2]) begin
            case (reg_addr[1:0])
               2'd0: sh_x <= reg_wdata[XW-1:0];
               2'd1: sh_y <= reg_wdata[XW-1:0];
               2'd2: if (reg_wdata[SHW-1:0] < SHW'(NUM_SHAPES)) sh_shape <= reg_wdata[SHW-1:0];
               default: ;
            endcase
         end
      end
   end

   // rectangle test and bitmap address
   logic [XW-1:0] dx, dy;
   logic [3:0]    wl, hl;
   logic          hit;
   logic [AW-1:0] rd_addr;

   assign dx      = pix_x - act_x;
   assign dy      = pix_y - act_y;
   assign wl      = 4'(BASE_LOG) + 4'(act_shape);
   assign hl      = 4'(AW) - wl;
   assign hit     = (pix_x >= act_x) && (pix_y >= act_y) &&
                    ((dx >> wl) == '0) && ((dy >> hl) == '0);
   assign rd_addr = (AW'(dy) << wl) | AW'(dx);

   logic [CODE_W-1:0] code_q;

   cursor_store #(.AW(AW), .DW(CODE_W)) u_store (
      .clk     (clk),
      .wr_en   (ram_wr),
      .wr_addr (ram_addr),
      .wr_data (ram_wdata),
      .rd_addr (rd_addr),
      .rd_data (code_q)
   );

   // stage 1
   logic            hit_q;
   logic [2:0][7:0] under_q;
   logic [XW-1:0]   px_q, py_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0; under_q <= '0; px_q <= '0; py_q <= '0;
      end else begin
         hit_q   <= hit;
         under_q <= {in_v, in_u, in_y};
         px_q    <= pix_x;
         py_q    <= pix_y;
      end
   end

   // stage 2: palette lookup and blend
   pal_entry_t      ent;
   logic [2:0][7:0] mixed;

   cursor_palette #(.IW(CODE_W)) u_pal (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr && reg_addr[2]),
      .wr_idx   (reg_addr[CODE_W-1:0]),
      .wr_data  (pal_entry_t'(reg_wdata[PAL_W-1:0])),
      .rd_idx   (code_q),
      .rd_entry (ent)
   );

   cursor_blend u_blend (
      .under (under_q),
      .ent   (ent),
      .hit   (hit_q),
      .mixed (mixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_y <= '0; out_u <= '0; out_v <= '0; out_pos_x <= '0; out_pos_y <= '0;
      end else begin
         out_y <= mixed[0]; out_u <= mixed[1]; out_v <= mixed[2];
         out_pos_x <= px_q; out_pos_y <= py_q;
      end
   end

   assert_shape_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act_shape < SHW'(NUM_SHAPES)) else $error("active shape out of range");

   assert_hold_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(act_x) && $stable(act_y) && $stable(act_shape))
      else $error("active set changed without field_start");

   assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_q |=> (out_y == $past(under_q[0])) && (out_u == $past(under_q[1])) &&
                 (out_v == $past(under_q[2])))
      else $error("pixel outside cursor altered");

   assert_pos_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_pos_x == $past(px_q)) && (out_pos_y == $past(py_q)))
      else $error("position delay mismatch");
endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        field_start = 1'b0;
   logic [11:0] pix_x = '0, pix_y = '0;
   logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        ram_wr = 1'b0;
   logic [9:0]  ram_addr = '0;
   logic [1:0]  ram_wdata = '0;
   logic [7:0]  out_y, out_u, out_v;
   logic [11:0] out_pos_x, out_pos_y;

   always #10 clk = ~clk;

   cursor_overlay u0 (.*);

   int checks = 0, fails = 0;
   string cur_req = "R1";

   // stimulus for the next step
   int s_x, s_y, s_py, s_pu, s_pv, s_ra, s_rd, s_ma, s_md;
   bit s_fs, s_rw, s_mw;

   // reference model
   int mram [1024];
   int mpal [4];
   int sh_x, sh_y, sh_s, a_x, a_y, a_s;

   // pipeline of expectations
   bit v1, v2;
   int q1_hit, q1_code, q1_p [3], q1_x, q1_y;
   int e2_hit, e2_c [3], e2_x, e2_y;

   function automatic int expand(int ch, int w);
      int y6, c4;
      y6 = (w >> 10) & 63;
      if (ch == 0) return (y6 << 2) | (y6 >> 4);
      c4 = (ch == 1) ? (w >> 6) & 15 : (w >> 2) & 15;
      return (c4 << 4) | c4;
   endfunction

   function automatic int mix(int c, int p, int t);
      return (c * t + p * (3 - t)) / 3;
   endfunction

   task automatic check(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic step();
      int w, h, t, wd;
      @(negedge clk);
      if (v2) begin
         check(e2_hit ? cur_req : "R3", int'(out_y), e2_c[0]);
         check(e2_hit ? cur_req : "R3", int'(out_u), e2_c[1]);
         check(e2_hit ? cur_req : "R3", int'(out_v), e2_c[2]);
         check("R2", int'({out_pos_y, out_pos_x}), (e2_y << 12) | e2_x);
      end
      v2 = v1;
      if (v1) begin
         wd = mpal[q1_code];
         t  = q1_hit ? (wd & 3) : 0;
         for (int c = 0; c < 3; c++) e2_c[c] = mix(expand(c, wd), q1_p[c], t);
         e2_hit = q1_hit && t != 0;
         e2_x = q1_x; e2_y = q1_y;
      end
      // stage-1 model with the state in force before this edge
      v1 = 1;
      w = 8 << a_s; h = 128 >> a_s;
      q1_hit = (s_x >= a_x) && (s_y >= a_y) && (s_x - a_x < w) && (s_y - a_y < h);
      q1_code = q1_hit ? mram[(s_y - a_y) * w + (s_x - a_x)] : 0;
      q1_p[0] = s_py; q1_p[1] = s_pu; q1_p[2] = s_pv; q1_x = s_x; q1_y = s_y;
      // state updates taken at this edge
      if (s_fs) begin a_x = sh_x; a_y = sh_y; a_s = sh_s; end
      if (s_mw) mram[s_ma] = s_md;
      if (s_rw) begin
         if (s_ra >= 4)      mpal[s_ra - 4] = s_rd;
         else if (s_ra == 0) sh_x = s_rd & 12'hfff;
         else if (s_ra == 1) sh_y = s_rd & 12'hfff;
         else if (s_ra == 2 && (s_rd & 7) < 5) sh_s = s_rd & 7;
      end
      pix_x = 12'(s_x); pix_y = 12'(s_y);
      in_y = 8'(s_py); in_u = 8'(s_pu); in_v = 8'(s_pv);
      field_start = s_fs;
      reg_wr = s_rw; reg_addr = 3'(s_ra); reg_wdata = 16'(s_rd);
      ram_wr = s_mw; ram_addr = 10'(s_ma); ram_wdata = 2'(s_md);
      s_fs = 0; s_rw = 0; s_mw = 0;
   endtask

   task automatic pix(int x, int y);
      s_x = x; s_y = y;
      s_py = int'($urandom_range(0, 255));
      s_pu = int'($urandom_range(0, 255));
      s_pv = int'($urandom_range(0, 255));
   endtask

   task automatic regw(int a, int d);
      s_rw = 1; s_ra = a; s_rd = d;
      pix(int'($urandom_range(0, 500)), int'($urandom_range(0, 500)));
      step();
   endtask

   task automatic scan(int x0, int x1, int y0, int y1);
      for (int y = y0; y <= y1; y++)
         for (int x = x0; x <= x1; x++) begin
            pix(x, y);
            step();
         end
   endtask

   task automatic place(int x, int y, int s);
      regw(0, x); regw(1, y); regw(2, s);
      s_fs = 1; pix(0, 0); step();
   endtask

   initial begin
      #(20ns * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = int'($urandom(32'd4711));
      foreach (mram[i]) mram[i] = 0;
      foreach (mpal[i]) mpal[i] = 0;
      sh_x = 0; sh_y = 0; sh_s = 2; a_x = 0; a_y = 0; a_s = 2;
      v1 = 0; v2 = 0;
      s_fs = 0; s_rw = 0; s_mw = 0;
      repeat (3) @(negedge clk);
      // R1: reset state of the outputs
      check("R1", int'(out_y) + int'(out_u) + int'(out_v), 0);
      check("R1", int'(out_pos_x) + int'(out_pos_y), 0);
      rst_n = 1'b1;
      // R1: transparent palette after reset, pixels pass through
      cur_req = "R1";
      for (int i = 0; i < 40; i++) begin pix(i, i / 2); step(); end
      // R5: load bitmap codes
      cur_req = "R5";
      for (int a = 0; a < 1024; a++) begin
         s_mw = 1; s_ma = a; s_md = (a ^ (a >> 3) ^ (a >> 7)) & 3;
         pix(a & 63, a >> 6); step();
      end
      // R6/R7: all entries opaque with distinct colours, scan default shape
      cur_req = "R7";
      regw(4, 16'b111111_0000_1111_11);
      regw(5, 16'b100001_1010_0101_11);
      regw(6, 16'b010110_0011_1100_11);
      regw(7, 16'b000001_1111_0001_11);
      regw(3, 16'hffff);
      scan(0, 33, 0, 33);
      // R6: mixed transparency levels
      cur_req = "R6";
      regw(4, 16'b000000_0000_0000_00);
      regw(5, 16'b110011_1001_0110_01);
      regw(6, 16'b001100_0110_1001_10);
      scan(0, 33, 0, 2);
      // R4: every shape in turn, margin around the rectangle
      cur_req = "R4";
      for (int s = 0; s < 5; s++) begin
         place(40 + s, 30, s);
         scan(38 + s, 40 + s + (8 << s), 29, 31 + (128 >> s));
      end
      // R4: illegal shape codes ignored
      regw(2, 6); regw(2, 5);
      s_fs = 1; pix(0, 0); step();
      scan(38, 46, 29, 40);
      // R9: write without field_start stays inactive, then write at field edge
      cur_req = "R9";
      regw(0, 200); regw(2, 2);
      scan(40, 50, 30, 34);
      s_fs = 1; s_rw = 1; s_ra = 1; s_rd = 150; pix(0, 0); step();
      scan(198, 234, 28, 34);
      s_fs = 1; pix(0, 0); step();
      scan(198, 234, 148, 152);
      // R10: rewrite the cell being read in the same cycle, then re-read
      cur_req = "R10";
      regw(7, 16'b101010_0101_1010_11);
      for (int k = 0; k < 8; k++) begin
         s_mw = 1; s_ma = k; s_md = 3; pix(200 + k, 150); step();
      end
      scan(200, 207, 150, 150);
      // R8: random mix of pixels, writes and field pulses
      cur_req = "R8";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) < 3) begin s_rw = 1; s_ra = int'($urandom_range(0, 7)); s_rd = int'($urandom_range(0, 65535)) & 16'h01ff | ((s_ra >= 4) ? int'($urandom_range(0, 65535)) : 0); end
         if ($urandom_range(0, 99) < 3) begin s_mw = 1; s_ma = int'($urandom_range(0, 1023)); s_md = int'($urandom_range(0, 3)); end
         if ($urandom_range(0, 99) < 2) s_fs = 1;
         pix(int'($urandom_range(0, 400)), int'($urandom_range(0, 400)));
         step();
      end
      repeat (3) begin pix(0, 0); step(); end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule